// File: doc/BRIEF.md
# Flash line buffer prefetch controller

This block sits between one CPU-side read port and a slow flash array. It keeps four 128-bit line buffers. Each buffer has a line-address tag and a valid bit, and buffers are replaced by least-recently-used order. A read that hits a buffer is answered from it. A read that misses fetches the whole line from the array. Depending on the selected policy, the block also speculatively fetches the line that follows. Toward the array it issues whole-line fetches, one at a time, and waits for a response strobe that carries the line.

Two configuration fields are written together through a write strobe and are cleared by reset:

- a 2-bit prefetch policy:
  - 00: no buffering at all.
  - 01: fill on miss.
  - upper bit set: fill on miss, and also prefetch the next line on a hit.
- a buffer enable bit. Dropping the enable empties the buffers and cancels the installation of any fill that is in flight.

A demand miss that arrives while a prefetch is outstanding waits for that prefetch to complete. When the prefetched line is the one demanded, the demand is answered straight from the returning data.

Top module: `flash_line_prefetch`

## Requirements
- R1: With policy 00, every accepted read is fetched from the array. No buffer is filled or consulted, and the same line read twice costs two fetches.
- R2: With policy 01, a miss fetches the line and installs it. Later reads of that line hit, and a hit starts no fetch.
- R3: With a policy whose upper bit is 1 (10 or 11), a hit starts a prefetch of line+1 (modulo 2^12). This happens only when that line is absent and no fetch is in flight. A miss starts only its own demand fetch.
- R4: Each accepted read starts at most one fetch. A hit taken while a fetch is outstanding starts none.
- R5: While buffer enable is 0, no read is served from a buffer, and all valid bits are clear from the cycle after enable is seen low.
- R6: A valid bit is set only when a line return completes. A fill during which enable went low is never installed, even if enable is back at 1 when the line returns.
- R7: After reset the policy is 00 and enable is 0, so reads go to the array until the configuration is written.
- R8: The four buffers hold distinct lines. When all are valid, a fill replaces the least recently used buffer; a hit or a fill counts as a use.
- R9: At most one line fetch is outstanding. A demand miss behind a prefetch of the same line is served by that prefetch's data. A demand miss for another line is fetched after the prefetch returns.
- R10: The read address is a byte address. Bits [15:4] select the line and bits [3:2] select 32-bit word k, taken from line bits [32k+31:32k]. `rsp_valid_o` is a one-cycle pulse, and a hit answers in the cycle right after acceptance.
- R11: `req_ready_o` is low while a demand miss is pending and in any cycle where `fl_rsp_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load policy and enable |
| cfg_mode_i | input | 2 | Prefetch policy (00 off, 01 miss, 1x miss and hit) |
| cfg_buf_en_i | input | 1 | Buffer enable |
| req_valid_i | input | 1 | Read request |
| req_addr_i | input | 16 | Byte address of the read |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_data_o | output | 32 | Read word |
| fl_req_o | output | 1 | One-cycle line fetch strobe toward the array |
| fl_line_o | output | 12 | Line address of the fetch |
| fl_rsp_valid_i | input | 1 | Line return strobe |
| fl_rsp_data_i | input | 128 | Returned line |

## Verification
The edge that accepts a read is counted as edge 0, and the array model answers LAT edges after it samples a fetch strobe.

| Case | Response registered at |
|---|---|
| Hit | edge 0 |
| Miss, fetch port idle | edge LAT+2 |
| Demand of a line already being prefetched | edge LAT |
| Demand of another line behind a prefetch | edge 2*LAT+2 |

The bench samples on the falling edge after each rising edge and counts those samples until the data strobe appears. It compares the count with these figures, so hit versus miss, waiting and invalidation are all judged from the latency. Fetch activity is checked by counting fetch strobes and recording the last line requested after the array model has gone quiet.

// File: rtl/flp_pkg.sv
package flp_pkg;
  typedef enum logic [1:0] {
    PF_NONE    = 2'b00,
    PF_MISS    = 2'b01,
    PF_MISSHIT = 2'b10,
    PF_MISSHT2 = 2'b11
  } pf_mode_e;

  localparam int PF_HIT_BIT = 1;
endpackage

// File: rtl/flp_line_store.sv
module flp_line_store #(
  parameter int NUM_BUF = 4,
  parameter int TAG_W   = 12,
  parameter int LINE_W  = 128,
  localparam int WAY_W  = $clog2(NUM_BUF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  output logic              a_hit_o,
  output logic [WAY_W-1:0]  a_way_o,
  output logic [LINE_W-1:0] a_line_o,
  input  logic [TAG_W-1:0]  b_tag_i,
  output logic              b_hit_o,
  output logic [NUM_BUF-1:0] valid_o
);
  logic [NUM_BUF-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [NUM_BUF];
  logic [LINE_W-1:0]  data_q [NUM_BUF];
  logic [NUM_BUF-1:0] match_a, match_b;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_way
    logic sel;
    assign sel = wr_i && (wr_way_i == WAY_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (clr_i) begin
        valid_q[g] <= 1'b0;
      end else if (sel) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= wr_tag_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel) data_q[g] <= wr_line_i;
    end

    assign match_a[g] = valid_q[g] && (tag_q[g] == a_tag_i);
    assign match_b[g] = valid_q[g] && (tag_q[g] == b_tag_i);
  end

  always_comb begin
    a_way_o = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (match_a[i]) a_way_o = WAY_W'(i);
    end
  end

  assign a_hit_o  = |match_a;
  assign b_hit_o  = |match_b;
  assign a_line_o = data_q[a_way_o];
  assign valid_o  = valid_q;

  assert_unique_tag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_a));
endmodule

// File: rtl/flp_lru.sv
module flp_lru #(
  parameter int NUM_BUF = 4,
  localparam int WAY_W  = $clog2(NUM_BUF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               touch_i,
  input  logic [WAY_W-1:0]   touch_way_i,
  input  logic [NUM_BUF-1:0] valid_i,
  output logic [WAY_W-1:0]   victim_o
);
  // rank 0 = most recent, NUM_BUF-1 = least recent
  logic [WAY_W-1:0] age_q [NUM_BUF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BUF; i++) age_q[i] <= WAY_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (WAY_W'(i) == touch_way_i)           age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_way_i]) age_q[i] <= age_q[i] + WAY_W'(1);
      end
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (!valid_i[i] && !found) begin
        victim_o = WAY_W'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (age_q[i] == WAY_W'(NUM_BUF - 1)) victim_o = WAY_W'(i);
      end
    end
  end

  logic [NUM_BUF-1:0] rank_seen;
  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < NUM_BUF; i++) rank_seen[age_q[i]] = 1'b1;
  end

  assert_lru_perm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rank_seen == {NUM_BUF{1'b1}});
endmodule

// File: rtl/flash_line_prefetch.sv
module flash_line_prefetch
  import flp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LINE_W  = 128,
  parameter int WORD_W  = 32,
  parameter int NUM_BUF = 4,
  localparam int OFF_W   = $clog2(LINE_W / 8),
  localparam int BOFF_W  = $clog2(WORD_W / 8),
  localparam int WSEL_W  = OFF_W - BOFF_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int WAY_W   = $clog2(NUM_BUF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic               cfg_buf_en_i,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               req_ready_o,
  output logic               rsp_valid_o,
  output logic [WORD_W-1:0]  rsp_data_o,
  output logic               fl_req_o,
  output logic [LADDR_W-1:0] fl_line_o,
  input  logic               fl_rsp_valid_i,
  input  logic [LINE_W-1:0]  fl_rsp_data_i
);
  pf_mode_e mode_q;
  logic     en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PF_NONE;
      en_q   <= 1'b0;
    end else if (cfg_we_i) begin
      mode_q <= pf_mode_e'(cfg_mode_i);
      en_q   <= cfg_buf_en_i;
    end
  end

  logic [LADDR_W-1:0] req_line, next_line, dem_line, fet_line, b_tag;
  logic [WSEL_W-1:0]  req_wsel, dem_wsel;
  logic               dem_pend, fet_busy, fet_abort, fl_req_q;
  logic               acc, buf_on, a_hit, b_hit, hit, miss_acc;
  logic               pf_start, dem_go, ret, fill, serve;
  logic [WAY_W-1:0]   a_way, victim;
  logic [LINE_W-1:0]  a_line;
  logic [NUM_BUF-1:0] buf_valid;
  logic               rsp_valid_q;
  logic [WORD_W-1:0]  rsp_data_q;

  logic unused_ok;
  assign unused_ok = ^req_addr_i[BOFF_W-1:0];

  assign req_line  = req_addr_i[ADDR_W-1:OFF_W];
  assign req_wsel  = req_addr_i[OFF_W-1:BOFF_W];
  assign next_line = req_line + LADDR_W'(1);

  // no acceptance in a return cycle: keeps lookup and fill apart
  assign req_ready_o = !dem_pend && !fl_rsp_valid_i;
  assign acc         = req_valid_i && req_ready_o;
  assign buf_on      = en_q && (mode_q != PF_NONE);

  assign hit      = acc && buf_on && a_hit;
  assign miss_acc = acc && !(buf_on && a_hit);
  assign pf_start = hit && mode_q[PF_HIT_BIT] && !b_hit && !fet_busy;
  assign dem_go   = dem_pend && !fet_busy;
  assign ret      = fl_rsp_valid_i && fet_busy;
  // port b checks the returning line, so a line is never held twice
  assign b_tag    = fl_rsp_valid_i ? fet_line : next_line;
  assign fill     = ret && buf_on && !fet_abort && !b_hit;
  assign serve    = ret && dem_pend && (fet_line == dem_line);

  flp_line_store #(
    .NUM_BUF (NUM_BUF),
    .TAG_W   (LADDR_W),
    .LINE_W  (LINE_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!en_q),
    .wr_i      (fill),
    .wr_way_i  (victim),
    .wr_tag_i  (fet_line),
    .wr_line_i (fl_rsp_data_i),
    .a_tag_i   (req_line),
    .a_hit_o   (a_hit),
    .a_way_o   (a_way),
    .a_line_o  (a_line),
    .b_tag_i   (b_tag),
    .b_hit_o   (b_hit),
    .valid_o   (buf_valid)
  );

  flp_lru #(
    .NUM_BUF (NUM_BUF)
  ) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (hit || fill),
    .touch_way_i (hit ? a_way : victim),
    .valid_i     (buf_valid),
    .victim_o    (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dem_pend  <= 1'b0;
      dem_line  <= '0;
      dem_wsel  <= '0;
      fet_busy  <= 1'b0;
      fet_abort <= 1'b0;
      fet_line  <= '0;
      fl_req_q  <= 1'b0;
    end else begin
      fl_req_q <= pf_start || dem_go;
      if (miss_acc) begin
        dem_pend <= 1'b1;
        dem_line <= req_line;
        dem_wsel <= req_wsel;
      end else if (serve) begin
        dem_pend <= 1'b0;
      end
      if (pf_start || dem_go) begin
        fet_busy  <= 1'b1;
        fet_abort <= 1'b0;
        fet_line  <= pf_start ? next_line : dem_line;
      end else if (ret) begin
        fet_busy <= 1'b0;
      end else if (fet_busy && !en_q) begin
        fet_abort <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= hit || serve;
      if (hit)        rsp_data_q <= a_line[int'(req_wsel) * WORD_W +: WORD_W];
      else if (serve) rsp_data_q <= fl_rsp_data_i[int'(dem_wsel) * WORD_W +: WORD_W];
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign fl_req_o    = fl_req_q;
  assign fl_line_o   = fet_line;

  // outstanding fetch count seen at the array port
  logic [1:0] out_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else if (fl_req_o && !(fl_rsp_valid_i && out_q != 2'd0)) out_q <= out_q + 2'd1;
    else if (!fl_req_o && fl_rsp_valid_i && out_q != 2'd0)   out_q <= out_q - 2'd1;
  end

  assert_single_fetch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q <= 2'd1);

  assert_off_goes_to_array_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && mode_q == PF_NONE) |=> dem_pend);

  assert_pf_only_mode_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !$past(dem_pend)) |-> $past(mode_q[PF_HIT_BIT]));

  assert_invalidate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (buf_valid == '0));

  assert_valid_after_return_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(buf_valid) > $countones($past(buf_valid))) |-> $past(fl_rsp_valid_i));

  assert_rsp_has_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(req_valid_i && req_ready_o) || $past(dem_pend)));
endmodule

// File: tb/sim_flash_line_prefetch.sv
module sim_flash_line_prefetch;
  localparam int LAT      = 3;
  localparam int HIT      = 1;
  localparam int MISS     = LAT + 3;
  localparam int PF_SAME  = LAT + 1;
  localparam int PF_OTHER = 2 * LAT + 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cfg_we_i = 1'b0;
  logic [1:0]   cfg_mode_i = 2'b00;
  logic         cfg_buf_en_i = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [15:0]  req_addr_i = '0;
  logic         req_ready_o, rsp_valid_o, fl_req_o;
  logic [31:0]  rsp_data_o;
  logic [11:0]  fl_line_o;
  logic         fl_rsp_valid_i = 1'b0;
  logic [127:0] fl_rsp_data_i = '0;

  int n_chk = 0, n_err = 0;
  int fetch_cnt = 0, last_line = -1, fcnt = 0, fline = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  flash_line_prefetch u0 (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_mode_i, .cfg_buf_en_i,
    .req_valid_i, .req_addr_i, .req_ready_o, .rsp_valid_o, .rsp_data_o,
    .fl_req_o, .fl_line_o, .fl_rsp_valid_i, .fl_rsp_data_i
  );

  function automatic logic [31:0] fw(input int line, input int w);
    return 32'h5A00_0000 | 32'(line << 4) | 32'(w);
  endfunction

  function automatic logic [127:0] line_data(input int line);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[k*32 +: 32] = fw(line, k);
    return d;
  endfunction

  // array model: answers LAT edges after it samples a fetch strobe
  always @(posedge clk_i) begin
    fl_rsp_valid_i <= 1'b0;
    if (fcnt == 1) begin
      fl_rsp_valid_i <= 1'b1;
      fl_rsp_data_i  <= line_data(fline);
    end
    if (fcnt > 0) fcnt <= fcnt - 1;
    if (fl_req_o) begin
      fcnt      <= LAT - 1;
      fline     <= int'(fl_line_o);
      last_line <= int'(fl_line_o);
      fetch_cnt <= fetch_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic en);
    cfg_we_i = 1'b1; cfg_mode_i = m; cfg_buf_en_i = en;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_rsp(inout int lat, output logic [31:0] dat);
    while (!rsp_valid_o && lat < 60) begin
      if (fl_rsp_valid_i) check("R11 ready low in return cycle", 32'(req_ready_o), 0);
      @(negedge clk_i);
      lat++;
    end
    dat = rsp_data_o;
  endtask

  task automatic rd(input int line, input int w, output int lat, output logic [31:0] dat);
    req_addr_i  = 16'((line << 4) | (w << 2));
    req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 1;
    wait_rsp(lat, dat);
  endtask

  task automatic rdc(input string tag, input int line, input int w, input int exp_lat);
    int lat;
    logic [31:0] dat;
    rd(line, w, lat, dat);
    check({tag, " latency"}, 32'(lat), 32'(exp_lat));
    check({tag, " data"}, dat, fw(line, w));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [31:0] dat;
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R7 reset ready", 32'(req_ready_o), 1);
    check("R7 reset rsp", 32'(rsp_valid_o), 0);
    check("R7 reset fetch", 32'(fl_req_o), 0);

    // R7: unconfigured, no buffering
    rdc("R7 first read", 1, 0, MISS);
    rdc("R7 repeat read", 1, 0, MISS);
    idle(8);
    check("R7 fetch count", 32'(fetch_cnt), 2);

    // R1: policy 00 with enable set
    cfg(2'b00, 1'b1);
    rdc("R1 read a", 1, 1, MISS);
    rdc("R1 read b", 1, 1, MISS);
    idle(8);
    check("R1 fetch count", 32'(fetch_cnt), 4);

    // R2 / R10: fill on miss, word sweep from buffer
    cfg(2'b01, 1'b1);
    rdc("R2 miss", 2, 0, MISS);
    for (int w = 1; w < 4; w++) rdc("R10 word select hit", 2, w, HIT);
    @(negedge clk_i);
    check("R10 single pulse", 32'(rsp_valid_o), 0);
    rdc("R2 hit", 2, 0, HIT);
    idle(10);
    check("R2 no fetch on hit", 32'(fetch_cnt), 5);

    // R3 / R9 / R4 with policy 10
    cfg(2'b10, 1'b1);
    rdc("R3 miss", 3, 2, MISS);
    idle(10);
    check("R3 miss starts one fetch", 32'(fetch_cnt), 6);
    rdc("R3 hit launches prefetch", 3, 0, HIT);
    rdc("R9 demand served by prefetch", 4, 3, PF_SAME);
    check("R3 prefetch count", 32'(fetch_cnt), 7);
    check("R3 prefetch line", 32'(last_line), 4);
    rdc("R3 hit launches second", 4, 1, HIT);
    rdc("R4 hit while busy", 4, 2, HIT);
    idle(12);
    check("R4 one fetch per access", 32'(fetch_cnt), 8);
    check("R4 line", 32'(last_line), 5);
    rdc("R3 next present", 3, 3, HIT);
    idle(10);
    check("R3 no prefetch when present", 32'(fetch_cnt), 8);

    // policy 11 and demand of another line behind a prefetch
    cfg(2'b11, 1'b1);
    rdc("R3 mode 11 hit", 5, 0, HIT);
    idle(10);
    check("R3 mode 11 prefetch line", 32'(last_line), 6);
    rdc("R3 hit on prefetched", 6, 1, HIT);
    idle(10);
    rdc("R3 hit on prefetched 2", 7, 0, HIT);
    rdc("R9 other line waits", 20, 0, PF_OTHER);
    idle(10);
    check("R9 fetch count", 32'(fetch_cnt), 12);
    check("R9 last line", 32'(last_line), 20);

    // R5: enable low disables and clears
    cfg(2'b11, 1'b0);
    rdc("R5 no hit while disabled", 7, 1, MISS);
    cfg(2'b11, 1'b1);
    rdc("R5 cleared after enable", 7, 1, MISS);
    rdc("R5 refilled", 7, 2, HIT);
    idle(10);

    // R8: LRU replacement
    cfg(2'b01, 1'b0);
    cfg(2'b01, 1'b1);
    for (int l = 10; l < 14; l++) rdc("R8 fill", l, 0, MISS);
    rdc("R8 touch", 10, 0, HIT);
    rdc("R8 fifth line", 14, 0, MISS);
    rdc("R8 kept 10", 10, 1, HIT);
    rdc("R8 kept 12", 12, 1, HIT);
    rdc("R8 kept 13", 13, 1, HIT);
    rdc("R8 kept 14", 14, 1, HIT);
    rdc("R8 evicted 11", 11, 1, MISS);

    // R6: fill aborted by enable drop is not installed
    req_addr_i  = 16'(30 << 4);
    req_valid_i = 1'b1;
    check("R11 ready before abort test", 32'(req_ready_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R11 ready low while pending", 32'(req_ready_o), 0);
    cfg_we_i = 1'b1; cfg_mode_i = 2'b01; cfg_buf_en_i = 1'b0;
    @(negedge clk_i);
    cfg_buf_en_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    lat = 3;
    wait_rsp(lat, dat);
    check("R6 aborted fill latency", 32'(lat), 32'(MISS));
    check("R6 aborted fill data", dat, fw(30, 0));
    rdc("R6 not installed", 30, 0, MISS);
    rdc("R6 later fill installed", 30, 1, HIT);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule